// File: doc/BRIEF.md
# Write-Through Write-Allocate Data Cache

This block sits between a processor's byte load/store port and a slower main-memory port. It holds two fully associative lines of two bytes each, addressed by a 5-bit byte address whose upper four bits are the line tag and whose lowest bit selects the byte within the line. Loads that hit are answered from the line storage without any memory traffic. Loads that miss fetch the whole two-byte block into a line and then return the requested byte.

Stores follow a write-through, write-allocate policy. A store that misses first brings the whole block into a line. The store byte is then merged into the line, and every store, hit or miss, also sends exactly that one byte to memory. Memory therefore never holds stale data, and replacing a line never produces a memory write. Two free-running counters report the number of hits and misses.

The processor raises `cpuReq` for one cycle while the block is idle. The block answers with a one-cycle `cpuReady` pulse once every memory transfer for that access has been acknowledged. The memory side holds `memReq` and its address, direction and data steady until `memAck` is pulsed.

Top module: `wt_cache`

## Requirements
- R1: After reset no line is valid, the LRU state points at line 0, both counters read 0, and `cpuReady` and `memReq` are low.
- R2: On a load miss the block issues one block read (`memWe`=0) at the block-aligned address {tag, 0}. It installs `memRdata` in the chosen line, with byte offset 0 in bits [7:0] and offset 1 in bits [15:8], and returns the addressed byte on `cpuRdata` with `cpuReady`.
- R3: A load hit raises `cpuReady` in the cycle after the request, with the stored byte on `cpuRdata` and no memory request.
- R4: A line hits only when its valid bit is set and its tag equals address bits [4:1]. An invalid line whose stored tag matches still misses.
- R5: A store hit updates the addressed byte in the line and issues exactly one byte write (`memWe`=1) with `memAddr` equal to the full store address and `memWdata` equal to the store byte.
- R6: A store miss first performs a block read that allocates a line, then merges the store byte into that line, then issues the single byte write. A later load of either byte of that block hits.
- R7: The replacement victim is line 0 if it is invalid, else line 1 if it is invalid, else the least recently used line. Every hit and every fill marks its line as most recently used.
- R8: Replacing a line never causes a memory write. `memWe` is asserted only during the byte write of a store.
- R9: `memReq`, `memWe` and `memAddr` stay stable until `memAck`. `cpuReady` is a single-cycle pulse that comes only after the last acknowledged transfer. With a memory latency of L cycles, a load miss or store hit completes in L+1 cycles and a store miss in 2L+2 cycles.
- R10: Each accepted access increments exactly one counter: `hitCount` on a hit, `missCount` on a miss. The counters do not change while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Access request, sampled while idle |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 5 | Byte address |
| cpuWdata | input | 8 | Store byte |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 8 | Load byte, valid with cpuReady |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = byte write, 0 = block read |
| memAddr | output | 5 | Transfer address |
| memWdata | output | 8 | Byte written on a store |
| memAck | input | 1 | One-cycle transfer acknowledge |
| memRdata | input | 16 | Block read data, valid with memAck |
| hitCount | output | 16 | Number of hits since reset |
| missCount | output | 16 | Number of misses since reset |

## Verification
The hardest situation to reach from the ports is a silent eviction: a line must be replaced when both lines are valid and the LRU bit decides. The evicted data is then read back to show that memory already holds the stored byte, with no write at eviction. The stimulus table builds this up step by step. It fills both lines, touches one line with hits so that the other becomes least recently used, forces a third tag in, and later reloads the evicted block to confirm it returns the written-through value. A mid-run reset then checks that an address whose tag still sits in storage misses because its valid bit is clear.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRITE, ST_RESP} ctrlState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic accept;   // request taken this cycle, lookup result is used
    logic fill;     // block read acknowledged, install line
    logic wrPhase;  // byte-write transfer in progress
  } dpStrobe_t;
endpackage

// File: rtl/wt_cache_dp.sv
`timescale 1ns/1ps
module wt_cache_dp
  import cache_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int OFFSET_W = 1,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dpStrobe_t                            strobe,
  input  logic                                 cpuWe,
  input  logic [ADDR_W-1:0]                    cpuAddr,
  input  logic [DATA_W-1:0]                    cpuWdata,
  input  logic [DATA_W*(1<<OFFSET_W)-1:0]      memRdata,
  output logic                                 hit,
  output logic [DATA_W-1:0]                    cpuRdata,
  output logic [ADDR_W-1:0]                    memAddr,
  output logic [DATA_W-1:0]                    memWdata,
  output logic [CNT_W-1:0]                     hitCount,
  output logic [CNT_W-1:0]                     missCount
);
  localparam int TAG_W  = ADDR_W - OFFSET_W;
  localparam int LINE_W = DATA_W * (1 << OFFSET_W);
  localparam int LINES  = 2;  // one LRU bit covers exactly two lines

  logic [LINES-1:0]  validQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [LINE_W-1:0] lineQ [LINES];
  logic              lruQ;     // index of least recently used line
  logic              victimQ;
  logic [ADDR_W-1:0] addrQ;
  logic              weQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  logic [LINES-1:0]  wayHit;
  logic              hitWay;
  logic              victim;
  logic [TAG_W-1:0]  reqTag;

  assign reqTag = cpuAddr[ADDR_W-1:OFFSET_W];

  for (genvar w = 0; w < LINES; w++) begin : g_cmp
    assign wayHit[w] = validQ[w] && (tagQ[w] == reqTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];
  assign victim = !validQ[0] ? 1'b0 : (!validQ[1] ? 1'b1 : lruQ);

  function automatic logic [LINE_W-1:0] mergeByte(
      input logic [LINE_W-1:0] line, input logic [OFFSET_W-1:0] off,
      input logic [DATA_W-1:0] b);
    logic [LINE_W-1:0] r;
    r = line;
    r[off*DATA_W +: DATA_W] = b;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pickByte(
      input logic [LINE_W-1:0] line, input logic [OFFSET_W-1:0] off);
    return line[off*DATA_W +: DATA_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= '0;
      lruQ      <= 1'b0;
      victimQ   <= 1'b0;
      addrQ     <= '0;
      weQ       <= 1'b0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      hitCount  <= '0;
      missCount <= '0;
      for (int i = 0; i < LINES; i++) begin
        tagQ[i]  <= '0;
        lineQ[i] <= '0;
      end
    end else begin
      if (strobe.accept) begin
        addrQ  <= cpuAddr;
        weQ    <= cpuWe;
        wdataQ <= cpuWdata;
        if (hit) begin
          hitCount <= hitCount + 1'b1;
          lruQ     <= ~hitWay;
          if (cpuWe)
            lineQ[hitWay] <= mergeByte(lineQ[hitWay], cpuAddr[OFFSET_W-1:0], cpuWdata);
          else
            rdataQ <= pickByte(lineQ[hitWay], cpuAddr[OFFSET_W-1:0]);
        end else begin
          missCount <= missCount + 1'b1;
          victimQ   <= victim;
        end
      end
      if (strobe.fill) begin
        validQ[victimQ] <= 1'b1;
        tagQ[victimQ]   <= addrQ[ADDR_W-1:OFFSET_W];
        lineQ[victimQ]  <= weQ ? mergeByte(memRdata, addrQ[OFFSET_W-1:0], wdataQ) : memRdata;
        lruQ            <= ~victimQ;
        rdataQ          <= pickByte(memRdata, addrQ[OFFSET_W-1:0]);
      end
    end
  end

  assign cpuRdata = rdataQ;
  assign memWdata = wdataQ;
  assign memAddr  = strobe.wrPhase ? addrQ
                                   : {addrQ[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
module wt_cache_ctrl
  import cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       hit,
  input  logic       memAck,
  output dpStrobe_t  strobe,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);
  ctrlState_t stateQ, stateD;
  logic       storeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      storeQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.accept) storeQ <= cpuWe;
    end
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          strobe.accept = 1'b1;
          if (!hit)       stateD = ST_FILL;
          else if (cpuWe) stateD = ST_WRITE;
          else            stateD = ST_RESP;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fill = 1'b1;
          stateD      = storeQ ? ST_WRITE : ST_RESP;
        end
      end
      ST_WRITE: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        strobe.wrPhase = 1'b1;
        if (memAck) stateD = ST_RESP;
      end
      ST_RESP: begin
        cpuReady = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
module wt_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int OFFSET_W = 1,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cpuReq,
  input  logic                            cpuWe,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [DATA_W-1:0]               cpuWdata,
  output logic                            cpuReady,
  output logic [DATA_W-1:0]               cpuRdata,
  output logic                            memReq,
  output logic                            memWe,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [DATA_W-1:0]               memWdata,
  input  logic                            memAck,
  input  logic [DATA_W*(1<<OFFSET_W)-1:0] memRdata,
  output logic [CNT_W-1:0]                hitCount,
  output logic [CNT_W-1:0]                missCount
);
  dpStrobe_t strobe;
  logic      hit;

  wt_cache_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .memAck(memAck), .strobe(strobe), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe)
  );

  wt_cache_dp #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .hit(hit), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memWdata(memWdata), .hitCount(hitCount), .missCount(missCount)
  );
endmodule

// File: rtl/wt_cache_chk.sv
`timescale 1ns/1ps
module wt_cache_chk #(
  parameter int ADDR_W   = 5,
  parameter int OFFSET_W = 1,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);
  logic              busyQ, storeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [CNT_W:0]    sumNow;

  assign sumNow = {1'b0, hitCount} + {1'b0, missCount};

  // independent record of the access in flight, seen from the ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0; storeQ <= 1'b0; addrQ <= '0; dataQ <= '0;
    end else if (!busyQ && cpuReq) begin
      busyQ <= 1'b1; storeQ <= cpuWe; addrQ <= cpuAddr; dataQ <= cpuWdata;
    end else if (cpuReady) begin
      busyQ <= 1'b0;
    end
  end

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(memAddr));

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !memReq && !cpuReady);

  assert_store_only_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> busyQ && storeQ && memAddr == addrQ && memWdata == dataQ);

  assert_block_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> memAddr[OFFSET_W-1:0] == '0 &&
                         memAddr[ADDR_W-1:OFFSET_W] == addrQ[ADDR_W-1:OFFSET_W]);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ && cpuReq |=> sumNow == $past(sumNow) + 1'b1);

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> $stable(hitCount) && $stable(missCount));
endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
  .hitCount(hitCount), .missCount(missCount)
);

// File: tb/wt_cache_tb_top.sv
`timescale 1ns/1ps
module wt_cache_tb_top;
  localparam int ADDR_W = 5, OFFSET_W = 1, DATA_W = 8, CNT_W = 16;
  localparam int LAT = 3;
  localparam int NVEC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuReady, memReq, memWe;
  logic [DATA_W-1:0] cpuRdata, memWdata;
  logic [ADDR_W-1:0] memAddr;
  logic memAck = 1'b0;
  logic [2*DATA_W-1:0] memRdata = '0;
  logic [CNT_W-1:0] hitCount, missCount;

  always #4 clk = ~clk;  // 125 MHz

  wt_cache #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .hitCount(hitCount), .missCount(missCount)
  );

  int nChecks = 0, nFails = 0;
  logic [7:0] mem [32];
  int rdCount = 0, wrCount = 0;
  logic [4:0] lastRdAddr = '0, lastWrAddr = '0;
  logic [7:0] lastWrData = '0;

  typedef struct packed {
    logic       we;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic       expHit;
    logic [7:0] expData;
  } vec_t;

  // memory initialised to 8'h40 + address; block byte 0 in memRdata[7:0]
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'd1,  8'h00, 1'b0, 8'h41},  // fill line 0 (R2, R7 invalid first)
    '{1'b0, 5'd7,  8'h00, 1'b0, 8'h47},  // fill line 1
    '{1'b1, 5'd0,  8'hAA, 1'b1, 8'h00},  // store hit (R5)
    '{1'b0, 5'd0,  8'h00, 1'b1, 8'hAA},  // load hit sees store (R3)
    '{1'b1, 5'd5,  8'hBB, 1'b0, 8'h00},  // store miss evicts LRU line 1 (R6)
    '{1'b0, 5'd4,  8'h00, 1'b1, 8'h44},  // other byte of allocated block hits
    '{1'b0, 5'd10, 8'h00, 1'b0, 8'h4A},  // evict line 0 silently (R8)
    '{1'b0, 5'd1,  8'h00, 1'b0, 8'h41},  // block 0 reloaded
    '{1'b0, 5'd5,  8'h00, 1'b0, 8'hBB},  // written-through byte back from memory
    '{1'b0, 5'd0,  8'h00, 1'b1, 8'hAA},
    '{1'b0, 5'd11, 8'h00, 1'b0, 8'h4B},
    '{1'b1, 5'd11, 8'hCC, 1'b1, 8'h00},
    '{1'b0, 5'd11, 8'h00, 1'b1, 8'hCC},
    '{1'b0, 5'd0,  8'h00, 1'b1, 8'hAA},  // hit moves LRU to the other line
    '{1'b0, 5'd20, 8'h00, 1'b0, 8'h54},  // victim must be line holding tag 5
    '{1'b0, 5'd1,  8'h00, 1'b1, 8'h41}   // block 0 survived (R7)
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: acknowledges LAT cycles after request is first seen
  initial begin
    int waitCnt;
    waitCnt = 0;
    for (int i = 0; i < 32; i++) mem[i] = 8'h40 + 8'(i);
    forever begin
      @(negedge clk);
      if (!rstN || memAck) begin
        memAck = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        waitCnt++;
        if (waitCnt == LAT) begin
          memAck = 1'b1;
          if (memWe) begin
            mem[memAddr] = memWdata;
            wrCount++;
            lastWrAddr = memAddr;
            lastWrData = memWdata;
          end else begin
            memRdata = {mem[{memAddr[4:1], 1'b1}], mem[{memAddr[4:1], 1'b0}]};
            rdCount++;
            lastRdAddr = memAddr;
          end
        end
      end
    end
  end

  task automatic doAccess(input logic we, input logic [4:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int cyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuReq = 1'b0;
    cyc = 1;
    while (!cpuReady && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    rd = cpuRdata;
    if (cyc >= 100) check(1'b0, "R9 access timeout", cyc, 0);
  endtask

  initial begin
    #(8ns * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int cyc, r0, w0, nXfer;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hitCount == 0 && missCount == 0, "R1 counters after reset", hitCount + missCount, 0);
    check(!cpuReady && !memReq, "R1 outputs idle after reset", {cpuReady, memReq}, 0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      r0 = rdCount; w0 = wrCount;
      doAccess(VECS[v].we, VECS[v].addr, VECS[v].wdata, rd, cyc);
      nXfer = int'(!VECS[v].expHit) + int'(VECS[v].we);
      // R9 completion timing: 1 + n*LAT + (n-1) for n transfers
      check(cyc == (nXfer == 0 ? 1 : 1 + nXfer * LAT + nXfer - 1),
            VECS[v].expHit && !VECS[v].we ? "R3 load hit latency" : "R9 ready after acks",
            cyc, (nXfer == 0 ? 1 : 1 + nXfer * LAT + nXfer - 1));
      if (!VECS[v].we)
        check(rd == VECS[v].expData, VECS[v].expHit ? "R3 hit data" : "R2 miss data",
              rd, VECS[v].expData);
      check(rdCount - r0 == int'(!VECS[v].expHit), "R7 hit or miss by replacement",
            rdCount - r0, int'(!VECS[v].expHit));
      if (!VECS[v].expHit)
        check(lastRdAddr == {VECS[v].addr[4:1], 1'b0}, "R2 block aligned read",
              lastRdAddr, {VECS[v].addr[4:1], 1'b0});
      check(wrCount - w0 == int'(VECS[v].we), "R8 writes only for stores",
            wrCount - w0, int'(VECS[v].we));
      if (VECS[v].we) begin
        check(lastWrAddr == VECS[v].addr && lastWrData == VECS[v].wdata,
              VECS[v].expHit ? "R5 byte write-through" : "R6 allocate then write",
              {lastWrAddr, lastWrData}, {VECS[v].addr, VECS[v].wdata});
      end
    end

    // R10 counters
    check(hitCount == 8, "R10 hit count", hitCount, 8);
    check(missCount == 8, "R10 miss count", missCount, 8);

    // mid-run reset, then a stored tag 0 must miss while invalid
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(hitCount == 0 && missCount == 0, "R1 counters cleared", hitCount + missCount, 0);
    rstN = 1'b1;
    r0 = rdCount;
    doAccess(1'b0, 5'd0, 8'h00, rd, cyc);
    check(rdCount - r0 == 1 && missCount == 1, "R4 invalid line misses", rdCount - r0, 1);
    check(rd == 8'hAA, "R4 data from memory after reset", rd, 8'hAA);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule